// File: doc/BRIEF.md
# Line-Prescaled Interrupt Timer

This block is an interrupt timer that runs on the CPU clock and has two counting modes. In line mode, a signed prescaler loses three units on each clock and gains back a full video-line period of 341 units each time it reaches zero or goes below it. This approximates one video line for every 113 or 114 CPU clocks, and each line advances an 8-bit up-counter by one. In cycle mode, the up-counter advances on every enabled clock. When the counter wraps from its all-ones value, it reloads from a reload latch and raises a level interrupt request toward the CPU.

Software drives the block through four single-cycle write strobes that share one byte-wide data bus. Two strobes fill the low and high nibbles of the reload latch. A third writes the control bits: mode, enable and a stored "re-arm" bit. The fourth is an acknowledge that copies the stored re-arm bit into enable. The control write and the acknowledge both drop the interrupt request. A control write that enables the timer also restarts the count from the latch and restarts the line prescaler.

Top module: `lineIrqTimer`

## Requirements
- R1: A `wrLatchLo` strobe loads latch bits [3:0] from `wrData[3:0]`, and a `wrLatchHi` strobe loads latch bits [7:4] from `wrData[3:0]`. `wrData[7:4]` has no effect on the latch.
- R2: A `wrCtrl` strobe stores mode from `wrData[2]` (0 = line mode, 1 = cycle mode), enable from `wrData[1]` and the re-arm bit from `wrData[0]`. It clears `irq` on the next clock.
- R3: A `wrCtrl` strobe with `wrData[1]`=1 loads the counter from the latch and sets the prescaler to 341. The restart takes effect even if the timer is already counting.
- R4: In line mode, each enabled clock subtracts 3 from the prescaler. When the result is 0 or less, 341 is added back and the counter gets one tick. The first tick lands 114 clocks after the enabling write, and ticks then repeat in a 114, 114, 113 clock pattern.
- R5: In cycle mode, the counter gets one tick on every enabled clock.
- R6: On a tick with the counter at 0xFF, the counter reloads from the latch and `irq` is set. The interrupt therefore comes 256 minus latch ticks after a restart, with the latch value taken before any same-cycle latch write.
- R7: On a tick with the counter below 0xFF, the counter increments by one.
- R8: A `wrAck` strobe copies the stored re-arm bit into enable and clears `irq`. It does not reload the counter.
- R9: While enable is 0, the counter and the prescaler hold their values. Re-enabling through `wrAck` resumes counting from the held count.
- R10: `irq` is a registered level. Once set, it stays high until a `wrCtrl` strobe, a `wrAck` strobe or reset.
- R11: Reset clears the latch, mode, enable, re-arm bit, counter, prescaler and `irq`.
- R12: In a clock cycle that carries a `wrCtrl` or `wrAck` strobe, the counter gets no tick and the prescaler does not step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| wrLatchLo | input | 1 | Write strobe, latch low nibble |
| wrLatchHi | input | 1 | Write strobe, latch high nibble |
| wrCtrl | input | 1 | Write strobe, control bits |
| wrAck | input | 1 | Write strobe, acknowledge |
| wrData | input | 8 | Write data shared by all strobes |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that at most one of the four write strobes is high in any cycle, and that each strobe lasts exactly one clock. With overlapping strobes, the priority between the control write and the acknowledge would decide the outcome, and the properties do not cover that case. The bench issues every register access through a single task that raises one strobe for one clock and lowers it before the next access. Between accesses, the bench lets the timer free-run so that wraps, holds and line timing can be seen on `irq`.

// File: rtl/lineTimerPkg.sv
`timescale 1ns/1ps
package lineTimerPkg;

  typedef enum logic {
    MODE_LINE  = 1'b0,
    MODE_CYCLE = 1'b1
  } countMode_t;

  typedef struct packed {
    logic latchLo;
    logic latchHi;
    logic loadCount;
    logic tick;
    logic clearIrq;
  } timerStrobes_t;

endpackage

// File: rtl/lineTimerCtrl.sv
`timescale 1ns/1ps
module lineTimerCtrl
  import lineTimerPkg::*;
#(
  parameter int PRE_W       = 10,
  parameter int LINE_PERIOD = 341,
  parameter int LINE_STEP   = 3,
  parameter int MODE_BIT    = 2,
  parameter int EN_BIT      = 1,
  parameter int REARM_BIT   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrLatchLo,
  input  logic          wrLatchHi,
  input  logic          wrCtrl,
  input  logic          wrAck,
  input  logic [2:0]    ctrlBits,
  output timerStrobes_t strobes
);

  localparam logic signed [PRE_W-1:0] PERIOD_S = PRE_W'(LINE_PERIOD);
  localparam logic signed [PRE_W-1:0] STEP_S   = PRE_W'(LINE_STEP);
  localparam logic signed [PRE_W-1:0] ZERO_S   = '0;

  countMode_t              mode;
  logic                    enable;
  logic                    rearm;
  logic signed [PRE_W-1:0] pre;
  logic signed [PRE_W-1:0] preStepped;
  logic                    lineDone;
  logic                    anyWrite;
  logic                    running;

  assign anyWrite   = wrCtrl | wrAck;
  assign running    = enable & ~anyWrite;
  assign preStepped = pre - STEP_S;
  assign lineDone   = (preStepped <= ZERO_S);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_LINE;
      enable <= 1'b0;
      rearm  <= 1'b0;
      pre    <= ZERO_S;
    end else if (wrCtrl) begin
      mode   <= countMode_t'(ctrlBits[MODE_BIT]);
      enable <= ctrlBits[EN_BIT];
      rearm  <= ctrlBits[REARM_BIT];
      if (ctrlBits[EN_BIT]) pre <= PERIOD_S;
    end else if (wrAck) begin
      enable <= rearm;
    end else if (running && mode == MODE_LINE) begin
      pre <= lineDone ? preStepped + PERIOD_S : preStepped;
    end
  end

  always_comb begin
    strobes.latchLo   = wrLatchLo;
    strobes.latchHi   = wrLatchHi;
    strobes.loadCount = wrCtrl & ctrlBits[EN_BIT];
    strobes.clearIrq  = anyWrite;
    strobes.tick      = running & ((mode == MODE_CYCLE) | lineDone);
  end

  a_r2_ctrl_fields: assert property (@(posedge clk) disable iff (rst)
    wrCtrl |=> (mode == countMode_t'($past(ctrlBits[MODE_BIT])))
               && (enable == $past(ctrlBits[EN_BIT]))
               && (rearm == $past(ctrlBits[REARM_BIT])));

  a_r3_pre_restart: assert property (@(posedge clk) disable iff (rst)
    (wrCtrl && ctrlBits[EN_BIT]) |=> (pre == PERIOD_S));

  a_r4_pre_range: assert property (@(posedge clk) disable iff (rst)
    (pre >= ZERO_S) && (pre <= PERIOD_S));

  a_r8_ack_copy: assert property (@(posedge clk) disable iff (rst)
    (wrAck && !wrCtrl) |=> (enable == $past(rearm)));

  a_r9_pre_hold: assert property (@(posedge clk) disable iff (rst)
    (!enable && !wrCtrl && !wrAck) |=> $stable(pre));

  a_r12_no_tick_on_write: assert property (@(posedge clk) disable iff (rst)
    (wrCtrl || wrAck) |-> !strobes.tick);

endmodule

// File: rtl/lineTimerData.sv
`timescale 1ns/1ps
module lineTimerData
  import lineTimerPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  timerStrobes_t    strobes,
  input  logic [NIB_W-1:0] nibble,
  output logic             irq
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] latch;
  logic [CNT_W-1:0] count;
  logic             atTop;

  assign atTop = (count == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
    end else begin
      if (strobes.latchLo) latch[NIB_W-1:0]     <= nibble;
      if (strobes.latchHi) latch[CNT_W-1:NIB_W] <= nibble;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      if (strobes.loadCount) begin
        count <= latch;
      end else if (strobes.tick) begin
        count <= atTop ? latch : count + 1'b1;
      end
      if (strobes.clearIrq) begin
        irq <= 1'b0;
      end else if (strobes.tick && atTop) begin
        irq <= 1'b1;
      end
    end
  end

  a_r1_latch_low: assert property (@(posedge clk) disable iff (rst)
    strobes.latchLo |=> (latch[NIB_W-1:0] == $past(nibble)));

  a_r1_latch_high: assert property (@(posedge clk) disable iff (rst)
    strobes.latchHi |=> (latch[CNT_W-1:NIB_W] == $past(nibble)));

  a_r6_wrap_reload: assert property (@(posedge clk) disable iff (rst)
    (strobes.tick && atTop && !strobes.loadCount) |=> (irq && count == $past(latch)));

  a_r7_increment: assert property (@(posedge clk) disable iff (rst)
    (strobes.tick && !atTop && !strobes.loadCount) |=> (count == $past(count) + 1'b1));

  a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobes.tick && !strobes.loadCount) |=> $stable(count));

  a_r10_irq_level: assert property (@(posedge clk) disable iff (rst)
    (irq && !strobes.clearIrq) |=> irq);

  a_r2_irq_clear: assert property (@(posedge clk) disable iff (rst)
    strobes.clearIrq |=> !irq);

endmodule

// File: rtl/lineIrqTimer.sv
`timescale 1ns/1ps
module lineIrqTimer
  import lineTimerPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 10,
  parameter int LINE_PERIOD = 341,
  parameter int LINE_STEP   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrLatchLo,
  input  logic              wrLatchHi,
  input  logic              wrCtrl,
  input  logic              wrAck,
  input  logic [DATA_W-1:0] wrData,
  output logic              irq
);

  localparam int NIB_W = CNT_W / 2;

  timerStrobes_t strobes;
  logic          unusedDataHigh;

  assign unusedDataHigh = ^wrData[DATA_W-1:NIB_W];

  lineTimerCtrl #(
    .PRE_W       (PRE_W),
    .LINE_PERIOD (LINE_PERIOD),
    .LINE_STEP   (LINE_STEP)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wrLatchLo (wrLatchLo),
    .wrLatchHi (wrLatchHi),
    .wrCtrl    (wrCtrl),
    .wrAck     (wrAck),
    .ctrlBits  (wrData[2:0]),
    .strobes   (strobes)
  );

  lineTimerData #(
    .CNT_W (CNT_W),
    .NIB_W (NIB_W)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .nibble  (wrData[NIB_W-1:0]),
    .irq     (irq)
  );

  a_r11_reset_quiet: assert property (@(posedge clk) rst |=> !irq);

endmodule

// File: tb/lineIrqTimer_bench.sv
`timescale 1ns/1ps
module lineIrqTimer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrLatchLo = 1'b0;
  logic       wrLatchHi = 1'b0;
  logic       wrCtrl = 1'b0;
  logic       wrAck = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       irq;

  int    cycleCount = 0;
  int    checks = 0;
  int    failures = 0;
  int    expCycle[$];
  string expTag[$];
  logic  prevIrq = 1'b0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  lineIrqTimer u_lineIrqTimer (
    .clk       (clk),
    .rst       (rst),
    .wrLatchLo (wrLatchLo),
    .wrLatchHi (wrLatchHi),
    .wrCtrl    (wrCtrl),
    .wrAck     (wrAck),
    .wrData    (wrData),
    .irq       (irq)
  );

  always @(posedge clk) cycleCount <= cycleCount + 1;

  // Monitor: every rising edge of irq must match the next scheduled expectation.
  always @(negedge clk) begin
    if (rst) begin
      prevIrq <= 1'b0;
    end else begin
      if (irq && !prevIrq) begin
        checks++;
        if (expCycle.size() == 0) begin
          failures++;
          $display("FAIL R6 unexpected irq rise: actual cycle %0d expected none", cycleCount);
        end else begin
          int    e;
          string t;
          e = expCycle.pop_front();
          t = expTag.pop_front();
          if (e != cycleCount) begin
            failures++;
            $display("FAIL %s irq rise: actual cycle %0d expected %0d", t, cycleCount, e);
          end
        end
      end
      prevIrq <= irq;
    end
  end

  task automatic expectRise(input int cyc, input string tag);
    expCycle.push_back(cyc);
    expTag.push_back(tag);
  endtask

  task automatic checkIrq(input string tag, input logic expVal);
    checks++;
    if (irq !== expVal) begin
      failures++;
      $display("FAIL %s irq level: actual %b expected %b", tag, irq, expVal);
    end
  endtask

  // which: 0 latch low, 1 latch high, 2 control, 3 acknowledge
  task automatic regWrite(input int which, input logic [7:0] d, output int edgeNo);
    wrData    = d;
    wrLatchLo = (which == 0);
    wrLatchHi = (which == 1);
    wrCtrl    = (which == 2);
    wrAck     = (which == 3);
    @(negedge clk);
    edgeNo    = cycleCount;
    wrLatchLo = 1'b0;
    wrLatchHi = 1'b0;
    wrCtrl    = 1'b0;
    wrAck     = 1'b0;
    wrData    = 8'h00;
  endtask

  task automatic setLatch(input logic [7:0] v);
    int e;
    regWrite(0, {4'hA, v[3:0]}, e);
    regWrite(1, {4'h5, v[7:4]}, e);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int a;
    int b;
    int e;
    waitCycles(3);
    checkIrq("R11", 1'b0);
    rst = 1'b0;
    waitCycles(2);

    // R1 R5 R6: nibble latch writes with junk high data bits, cycle mode, latch 0xFD
    regWrite(0, 8'hAD, e);
    regWrite(1, 8'h5F, e);
    regWrite(2, 8'h07, a);
    expectRise(a + 3, "R1");
    waitCycles(3);
    // R8 R12: acknowledge with re-arm=1 clears irq, keeps counting, write cycle skips a tick
    regWrite(3, 8'h00, b);
    checkIrq("R8", 1'b0);
    expectRise(b + 3, "R12");
    waitCycles(3);
    waitCycles(20);
    checkIrq("R10", 1'b1);
    // R2: control write clears irq and disables
    regWrite(2, 8'h00, e);
    checkIrq("R2", 1'b0);
    waitCycles(30);
    checkIrq("R2", 1'b0);

    // R9: hold while disabled, resume from held count through acknowledge
    setLatch(8'hF0);
    regWrite(2, 8'h07, a);
    waitCycles(4);
    regWrite(2, 8'h05, e);
    waitCycles(50);
    checkIrq("R9", 1'b0);
    regWrite(3, 8'h00, b);
    expectRise(b + 12, "R9");
    waitCycles(12);
    checkIrq("R9", 1'b1);
    regWrite(2, 8'h00, e);

    // R7 R8: acknowledge with re-arm=0 disables the timer
    setLatch(8'hFE);
    regWrite(2, 8'h06, a);
    expectRise(a + 2, "R7");
    waitCycles(2);
    regWrite(3, 8'h00, b);
    checkIrq("R8", 1'b0);
    waitCycles(40);
    checkIrq("R8", 1'b0);

    // R3: enabling control write restarts a running count
    setLatch(8'hF0);
    regWrite(2, 8'h06, a);
    waitCycles(10);
    regWrite(2, 8'h06, b);
    expectRise(b + 16, "R3");
    waitCycles(16);
    checkIrq("R3", 1'b1);
    regWrite(2, 8'h00, e);

    // R4: line mode, 1/2/3 lines take 114/228/341 clocks
    setLatch(8'hFF);
    regWrite(2, 8'h02, a);
    expectRise(a + 114, "R4");
    waitCycles(114);
    checkIrq("R4", 1'b1);
    regWrite(2, 8'h00, e);
    setLatch(8'hFE);
    regWrite(2, 8'h02, a);
    expectRise(a + 228, "R4");
    waitCycles(228);
    checkIrq("R4", 1'b1);
    regWrite(2, 8'h00, e);
    setLatch(8'hFD);
    regWrite(2, 8'h02, a);
    expectRise(a + 341, "R4");
    waitCycles(341);
    checkIrq("R4", 1'b1);
    regWrite(2, 8'h00, e);

    // R11: reset mid-operation clears irq and the latch
    setLatch(8'hFF);
    regWrite(2, 8'h06, a);
    expectRise(a + 1, "R6");
    waitCycles(3);
    checkIrq("R10", 1'b1);
    rst = 1'b1;
    waitCycles(1);
    checkIrq("R11", 1'b0);
    rst = 1'b0;
    waitCycles(20);
    checkIrq("R11", 1'b0);
    regWrite(2, 8'h06, a);
    expectRise(a + 256, "R11");
    waitCycles(256);
    checkIrq("R11", 1'b1);
    regWrite(2, 8'h00, e);
    waitCycles(5);

    checks++;
    if (expCycle.size() != 0) begin
      failures++;
      $display("FAIL R6 missing irq rises: actual %0d pending expected 0", expCycle.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule